// File: doc/BRIEF.md
# Peripheral port permission controller

This block holds the access attributes for a group of peripheral ports, one bit per port. Three mask registers are kept. The security mask sets which ports are non-secure, and the secure privilege mask sets the privilege level of ports that stay secure. Both are written through the secure register view. The third mask is the non-secure privilege mask, and only the non-secure register view can write it. Every mask is as wide as the number of ports, and that number is a parameter from 1 to 32.

Each port gets a non-secure output and a privilege output. The non-secure output follows the security mask. The security bit of each port then chooses which privilege mask drives that port's privilege output. A non-secure port takes its privilege bit from the mask owned by the non-secure view, and a secure port takes it from the secure privilege mask. The masks are also presented as 32-bit words for register readback. The bus filtering that acts on these outputs lives in a different block.

Top module: `ppc_perm_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, all three masks read zero and every port's non-secure and privilege outputs are 0.
- R2: A cycle with the secure-view security strobe high loads sec_wdata into the security mask. Only bits below NPORTS are kept, and readback bits at NPORTS and above read 0.
- R3: A cycle with the secure-view privilege strobe high loads sec_wdata into the secure privilege mask, with the same truncation to NPORTS bits.
- R4: A cycle with the non-secure-view strobe high loads nsv_wdata into the non-secure privilege mask, with the same truncation. This mask takes no data from sec_wdata.
- R5: port_nonsec[i] equals bit i of the security mask.
- R6: port_priv[i] equals bit i of the non-secure privilege mask when port i is non-secure (bit i of the security mask is 1). Otherwise it equals bit i of the secure privilege mask.
- R7: A write changes the readback and the port outputs in the first cycle after the clock edge that captured it.
- R8: A mask whose strobe is low keeps its value, whatever appears on either data bus.
- R9: Strobes raised in the same cycle each update their own mask independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_ns_we | input | 1 | Secure view: write the security mask |
| sec_sp_we | input | 1 | Secure view: write the secure privilege mask |
| sec_wdata | input | 32 | Secure view write data |
| nsv_nsp_we | input | 1 | Non-secure view: write the non-secure privilege mask |
| nsv_wdata | input | 32 | Non-secure view write data |
| ns_rd | output | 32 | Security mask readback, zero-extended |
| sp_rd | output | 32 | Secure privilege mask readback, zero-extended |
| nsp_rd | output | 32 | Non-secure privilege mask readback, zero-extended |
| port_nonsec | output | NPORTS | Per-port non-secure attribute |
| port_priv | output | NPORTS | Per-port privilege attribute |

## Verification
The bench drives two instances with the same stimulus. One has 5 ports and the other has the full 32. With 5 ports, all-ones and alternating data patterns land on readback bits that must stay zero, which exercises truncation. The 32-port instance reaches the top bit of the masks and the case where nothing is truncated. A pseudo-random run with mixed strobes brings up held masks, simultaneous writes, and ports whose security bit flips under a fixed pair of privilege masks, so both choices of privilege source are seen on many ports.

// File: rtl/ppc_perm_ctrl.sv
module ppc_perm_ctrl #(
  parameter int NPORTS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_ns_we,
  input  logic              sec_sp_we,
  input  logic [31:0]       sec_wdata,
  input  logic              nsv_nsp_we,
  input  logic [31:0]       nsv_wdata,
  output logic [31:0]       ns_rd,
  output logic [31:0]       sp_rd,
  output logic [31:0]       nsp_rd,
  output logic [NPORTS-1:0] port_nonsec,
  output logic [NPORTS-1:0] port_priv
);

  logic [NPORTS-1:0] ns_q, sp_q, nsp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ns_q  <= '0;
      sp_q  <= '0;
      nsp_q <= '0;
    end else begin
      if (sec_ns_we)  ns_q  <= sec_wdata[NPORTS-1:0];
      if (sec_sp_we)  sp_q  <= sec_wdata[NPORTS-1:0];
      if (nsv_nsp_we) nsp_q <= nsv_wdata[NPORTS-1:0];
    end
  end

  assign ns_rd  = 32'(ns_q);
  assign sp_rd  = 32'(sp_q);
  assign nsp_rd = 32'(nsp_q);

  assign port_nonsec = ns_q;
  assign port_priv   = (ns_q & nsp_q) | (~ns_q & sp_q);

  logic unused_hi;
  assign unused_hi = ^{sec_wdata, nsv_wdata};

  assert_ns_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sec_ns_we |=> ns_rd == 32'($past(sec_wdata[NPORTS-1:0])));

  assert_sp_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sec_sp_we |=> sp_rd == 32'($past(sec_wdata[NPORTS-1:0])));

  assert_nsp_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    nsv_nsp_we |=> nsp_rd == 32'($past(nsv_wdata[NPORTS-1:0])));

  assert_ns_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_ns_we |=> $stable(ns_rd) && $stable(port_nonsec));

  assert_priv_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_ns_we && !sec_sp_we && !nsv_nsp_we) |=> $stable(port_priv));

endmodule

// File: tb/ppc_perm_ctrl_test.sv
`timescale 1ns/1ps
module ppc_perm_ctrl_test;
  localparam int NA = 5;
  localparam int NB = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we_ns = 1'b0, we_sp = 1'b0, we_nsp = 1'b0;
  logic [31:0] sd = '0, nd = '0;

  logic [31:0] a_ns, a_sp, a_nsp, b_ns, b_sp, b_nsp;
  logic [NA-1:0] a_nonsec, a_priv;
  logic [NB-1:0] b_nonsec, b_priv;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [31:0] ma_ns, ma_sp, ma_nsp, mb_ns, mb_sp, mb_nsp;

  always #2.5 clk = ~clk;

  ppc_perm_ctrl #(.NPORTS(NA)) uut (
    .clk(clk), .rst_n(rst_n), .sec_ns_we(we_ns), .sec_sp_we(we_sp),
    .sec_wdata(sd), .nsv_nsp_we(we_nsp), .nsv_wdata(nd),
    .ns_rd(a_ns), .sp_rd(a_sp), .nsp_rd(a_nsp),
    .port_nonsec(a_nonsec), .port_priv(a_priv));

  ppc_perm_ctrl #(.NPORTS(NB)) uut_full (
    .clk(clk), .rst_n(rst_n), .sec_ns_we(we_ns), .sec_sp_we(we_sp),
    .sec_wdata(sd), .nsv_nsp_we(we_nsp), .nsv_wdata(nd),
    .ns_rd(b_ns), .sp_rd(b_sp), .nsp_rd(b_nsp),
    .port_nonsec(b_nonsec), .port_priv(b_priv));

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] privx(input logic [31:0] n, input logic [31:0] s,
                                        input logic [31:0] p, input int np);
    logic [31:0] r = '0;
    for (int i = 0; i < np; i++) r[i] = n[i] ? p[i] : s[i];
    return r;
  endfunction

  task automatic compare(input string tag);
    chk({tag, "/R2"}, "A ns_rd",  a_ns,  ma_ns);
    chk({tag, "/R3"}, "A sp_rd",  a_sp,  ma_sp);
    chk({tag, "/R4"}, "A nsp_rd", a_nsp, ma_nsp);
    chk({tag, "/R5"}, "A nonsec", 32'(a_nonsec), ma_ns);
    chk({tag, "/R6"}, "A priv",   32'(a_priv), privx(ma_ns, ma_sp, ma_nsp, NA));
    chk({tag, "/R2"}, "B ns_rd",  b_ns,  mb_ns);
    chk({tag, "/R3"}, "B sp_rd",  b_sp,  mb_sp);
    chk({tag, "/R4"}, "B nsp_rd", b_nsp, mb_nsp);
    chk({tag, "/R5"}, "B nonsec", b_nonsec, mb_ns);
    chk({tag, "/R6"}, "B priv",   b_priv, privx(mb_ns, mb_sp, mb_nsp, NB));
  endtask

  // One clock: drive, let the edge capture, update the model, sample mid-cycle (R7)
  task automatic cyc(input string tag, input logic wn, input logic ws, input logic wp,
                     input logic [31:0] s, input logic [31:0] n);
    we_ns = wn; we_sp = ws; we_nsp = wp; sd = s; nd = n;
    @(posedge clk); #1;
    if (wn) begin ma_ns  = s & ((32'd1 << NA) - 1); mb_ns  = s; end
    if (ws) begin ma_sp  = s & ((32'd1 << NA) - 1); mb_sp  = s; end
    if (wp) begin ma_nsp = n & ((32'd1 << NA) - 1); mb_nsp = n; end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic model_clear();
    ma_ns = '0; ma_sp = '0; ma_nsp = '0; mb_ns = '0; mb_sp = '0; mb_nsp = '0;
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr = 32'h1ACE_B00C;
    model_clear();
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after release");

    cyc("R2 all ones", 1, 0, 0, 32'hFFFF_FFFF, 32'h0);
    cyc("R3 pattern",  0, 1, 0, 32'hA5A5_A5A5, 32'hFFFF_FFFF);
    cyc("R4 pattern",  0, 0, 1, 32'h1234_5678, 32'h5A5A_5A5A);
    cyc("R8 idle data", 0, 0, 0, 32'hDEAD_BEEF, 32'hCAFE_F00D);
    cyc("R6 flip ns",  1, 0, 0, 32'h0F0F_0F0A, 32'h0);
    cyc("R9 all three", 1, 1, 1, 32'h8000_0013, 32'h7FFF_FFEC);
    cyc("R7 clear ns", 1, 0, 0, 32'h0, 32'hFFFF_FFFF);

    for (int k = 0; k < 300; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      cyc("R9 random", lfsr[3], lfsr[9], lfsr[17], lfsr ^ 32'h3C3C_C3C3, ~lfsr);
    end

    #1 rst_n = 1'b0;
    model_clear();
    #1 compare("R1 mid-run reset");
    @(negedge clk);
    rst_n = 1'b1;
    cyc("R1 post reset idle", 0, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule